// File: doc/BRIEF.md
# Nibble-Wide Target Communication Controller

This block links a host byte stream to a device under test that is reached over a 4-bit bus paced by handshakes. Command bytes arrive on a valid/ready input stream. Each byte is split into two nibbles, and each nibble is passed to the device with a four-phase handshake: the controller raises its request line, the device answers, the controller drops its request, and the device drops its answer. When the controller accepts a command byte marked as the last of its packet, it switches to the receive phase. In that phase it collects exactly the programmed number of result bytes. Each result byte is packed from two nibbles and leaves on a valid/ready output stream, and the final byte carries `m_tlast`. The controller then returns to the send phase.

A mode pin selects one of two bus arrangements. In half-duplex mode one nibble bus is shared, and a direction line driven only by the controller says who owns it. In that mode the controller releases its drivers one cycle before it hands the bus to the device, and it drives again only one cycle after it takes the bus back. In full-duplex mode separate input and output nibble buses are used, and no turnaround takes place. A device-busy input stops the controller from starting any nibble transfer. A reset line to the device follows the block's own reset.

Back-pressure rules: an input byte is taken in a cycle where `s_tvalid` and `s_tready` are both high. `s_tready` does not depend on `s_tvalid`. A result byte stays on `m_tdata`/`m_tlast` with `m_tvalid` high until `m_tready` is seen high. The controller does not begin a new result byte while one is still waiting.

Top module: `nib_target_ctrl`

## Requirements
- R1: While `rst_n` is low, `dut_rst` is 1, `hs_c2d` is 0, `dir_ctl` is 1, `hd_doe` is 1 (half-duplex), `m_tvalid` is 0 and `s_tready` is 0. `dut_rst` goes to 0 on the first clock edge after reset is released.
- R2: Each accepted byte is sent as two nibble transfers, bits 7:4 first and then bits 3:0. The nibble is present on `hd_dout` (half-duplex) or `fd_dout` (full-duplex) for as long as `hs_c2d` is high.
- R3: For each nibble, `hs_c2d` stays high until `hs_d2c` is seen high, then falls. The next transfer does not start before `hs_d2c` has been seen low.
- R4: No nibble transfer starts, and no input byte is accepted, in a cycle where `dut_busy` is 1.
- R5: In half-duplex mode, `dir_ctl` = 1 means the controller owns the bus and `dir_ctl` = 0 means the device owns it. `hd_doe` falls one cycle before `dir_ctl` falls, and `hd_doe` rises one cycle after `dir_ctl` rises. `hd_doe` is never 1 while `dir_ctl` is 0.
- R6: In the receive phase, a nibble is captured when `hs_d2c` is seen high while `hs_c2d` is high. The first nibble of a byte becomes bits 7:4 and the second becomes bits 3:0.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R8: After a command byte with `s_tlast` = 1, exactly `out_len` result bytes are delivered. `m_tlast` is 1 on the byte whose count equals `out_len` and 0 on the others. Sending then resumes.
- R9: With `out_len` = 0, a byte with `s_tlast` = 1 produces no result bytes. The controller keeps the bus, with `dir_ctl` = 1 and `hd_doe` = 1.
- R10: With `mode_full` = 1, data is taken from `fd_din` and placed on `fd_dout`, `hd_doe` stays 0 and `dir_ctl` stays 1.
- R11: The result-byte count clears after each `m_tlast`, so the next packet again ends at `out_len` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_full | input | 1 | 1 = separate buses, 0 = shared bus; change only between packets |
| out_len | input | LEN_W | Result bytes expected per packet; hold stable during a packet |
| s_tdata | input | 2*NIB_W | Command byte |
| s_tvalid | input | 1 | Command byte valid |
| s_tlast | input | 1 | Last command byte of the packet |
| s_tready | output | 1 | Controller can take a command byte |
| m_tdata | output | 2*NIB_W | Result byte |
| m_tvalid | output | 1 | Result byte valid |
| m_tlast | output | 1 | Final result byte of the packet |
| m_tready | input | 1 | Host can take a result byte |
| dut_rst | output | 1 | Reset to the device, active high |
| dir_ctl | output | 1 | Shared-bus owner: 1 controller, 0 device |
| hd_dout | output | NIB_W | Shared-bus value driven by the controller |
| hd_doe | output | 1 | Shared-bus driver enable |
| hd_din | input | NIB_W | Shared-bus value seen from the pins |
| fd_dout | output | NIB_W | Full-duplex nibble to the device |
| fd_din | input | NIB_W | Full-duplex nibble from the device |
| hs_c2d | output | 1 | Handshake from controller to device |
| hs_d2c | input | 1 | Handshake from device to controller |
| dut_busy | input | 1 | Device is busy processing |

## Verification
The checks assume the device keeps its side of the four-phase rule: it raises `hs_d2c` only while `hs_c2d` is high and lowers it only after `hs_c2d` has fallen. They also assume that `mode_full` and `out_len` change only while the controller waits in the send phase with no result byte pending. The bench's device model answers each request only after seeing the controller's line high, waits for it to fall before releasing its own, and varies its reply delay from zero to two cycles. The driver changes the mode and the length only after every queued transfer and result has drained.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [2:0] {
    SQ_TX_IDLE,
    SQ_TX_NEXT,
    SQ_TX_XFER,
    SQ_TURN_RX,
    SQ_RX_NEXT,
    SQ_RX_XFER,
    SQ_TURN_TX
  } seq_st_t;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_UP,
    HS_DN
  } hs_st_t;
endpackage

// File: rtl/nib_hs4.sv
module nib_hs4
  import nib_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic d2c,
  output logic c2d,
  output logic take,
  output logic done
);
  hs_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HS_IDLE;
    end else begin
      case (st)
        HS_IDLE: if (start) st <= HS_UP;
        HS_UP:   if (d2c)   st <= HS_DN;
        HS_DN:   if (!d2c)  st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  // request line is high only in the raise phase
  assign c2d  = (st == HS_UP);
  assign take = (st == HS_UP) && d2c;
  assign done = (st == HS_DN) && !d2c;
endmodule

// File: rtl/nib_len_cnt.sv
module nib_len_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [LEN_W-1:0] out_len,
  output logic             is_last
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   nxt;

  assign nxt     = {1'b0, cnt} + 1'b1;
  assign is_last = (nxt == {1'b0, out_len});

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (inc) cnt <= is_last ? '0 : nxt[LEN_W-1:0];
  end
endmodule

// File: rtl/nib_target_ctrl.sv
module nib_target_ctrl
  import nib_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_full,
  input  logic [LEN_W-1:0]   out_len,
  input  logic [2*NIB_W-1:0] s_tdata,
  input  logic               s_tvalid,
  input  logic               s_tlast,
  output logic               s_tready,
  output logic [2*NIB_W-1:0] m_tdata,
  output logic               m_tvalid,
  output logic               m_tlast,
  input  logic               m_tready,
  output logic               dut_rst,
  output logic               dir_ctl,
  output logic [NIB_W-1:0]   hd_dout,
  output logic               hd_doe,
  input  logic [NIB_W-1:0]   hd_din,
  output logic [NIB_W-1:0]   fd_dout,
  input  logic [NIB_W-1:0]   fd_din,
  output logic               hs_c2d,
  input  logic               hs_d2c,
  input  logic               dut_busy
);
  localparam int BYTE_W = 2 * NIB_W;

  seq_st_t           st;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_last;
  logic              nib_lo;
  logic [NIB_W-1:0]  rx_hi, rx_lo, din, cur_nib;
  logic              dir_q, doe_q, rst_q;
  logic              hs_start, hs_take, hs_done, len_last, rx_byte_done;

  nib_hs4 u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hs_start),
    .d2c   (hs_d2c),
    .c2d   (hs_c2d),
    .take  (hs_take),
    .done  (hs_done)
  );

  nib_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (rx_byte_done),
    .out_len (out_len),
    .is_last (len_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b1;
    else        rst_q <= 1'b0;
  end
  assign dut_rst = rst_q;

  assign s_tready = (st == SQ_TX_IDLE) && !dut_busy && !rst_q;

  always_comb begin
    case (st)
      SQ_TX_IDLE: hs_start = s_tvalid && s_tready;
      SQ_TX_NEXT: hs_start = !dut_busy;
      SQ_RX_NEXT: hs_start = !dut_busy && (nib_lo || !m_tvalid);
      default:    hs_start = 1'b0;
    endcase
  end

  assign rx_byte_done = (st == SQ_RX_XFER) && hs_done && nib_lo;
  assign din          = mode_full ? fd_din : hd_din;
  assign cur_nib      = nib_lo ? tx_byte[NIB_W-1:0] : tx_byte[BYTE_W-1:NIB_W];
  assign hd_dout      = cur_nib;
  assign fd_dout      = cur_nib;
  assign hd_doe       = doe_q && !mode_full;
  assign dir_ctl      = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_TX_IDLE;
      tx_byte  <= '0;
      tx_last  <= 1'b0;
      nib_lo   <= 1'b0;
      rx_hi    <= '0;
      rx_lo    <= '0;
      dir_q    <= 1'b1;
      doe_q    <= 1'b1;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else begin
      if (m_tvalid && m_tready) m_tvalid <= 1'b0;
      if (hs_take && st == SQ_RX_XFER) begin
        if (nib_lo) rx_lo <= din;
        else        rx_hi <= din;
      end
      case (st)
        SQ_TX_IDLE: if (hs_start) begin
          tx_byte <= s_tdata;
          tx_last <= s_tlast;
          nib_lo  <= 1'b0;
          st      <= SQ_TX_XFER;
        end
        SQ_TX_NEXT: if (hs_start) st <= SQ_TX_XFER;
        SQ_TX_XFER: if (hs_done) begin
          if (!nib_lo) begin
            nib_lo <= 1'b1;
            st     <= SQ_TX_NEXT;
          end else begin
            nib_lo <= 1'b0;
            if (tx_last && out_len != '0) begin
              if (mode_full) st <= SQ_RX_NEXT;
              else begin
                doe_q <= 1'b0;          // release drivers first
                st    <= SQ_TURN_RX;
              end
            end else begin
              st <= SQ_TX_IDLE;
            end
          end
        end
        SQ_TURN_RX: begin
          dir_q <= 1'b0;                // hand bus to device
          st    <= SQ_RX_NEXT;
        end
        SQ_RX_NEXT: if (hs_start) st <= SQ_RX_XFER;
        SQ_RX_XFER: if (hs_done) begin
          if (!nib_lo) begin
            nib_lo <= 1'b1;
            st     <= SQ_RX_NEXT;
          end else begin
            nib_lo   <= 1'b0;
            m_tdata  <= {rx_hi, rx_lo};
            m_tvalid <= 1'b1;
            m_tlast  <= len_last;
            if (!len_last)      st <= SQ_RX_NEXT;
            else if (mode_full) st <= SQ_TX_IDLE;
            else begin
              dir_q <= 1'b1;            // take bus back first
              st    <= SQ_TURN_TX;
            end
          end
        end
        SQ_TURN_TX: begin
          doe_q <= 1'b1;
          st    <= SQ_TX_IDLE;
        end
        default: st <= SQ_TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nib_target_ctrl_chk.sv
module nib_target_ctrl_chk #(
  parameter int NIB_W = 4,
  parameter int LEN_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_full,
  input logic [LEN_W-1:0]   out_len,
  input logic [2*NIB_W-1:0] m_tdata,
  input logic               m_tvalid,
  input logic               m_tlast,
  input logic               m_tready,
  input logic               dir_ctl,
  input logic               hd_doe,
  input logic               hs_c2d,
  input logic               hs_d2c,
  input logic               dut_busy
);
  a_r3_drop_after_answer: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_c2d) |-> $past(hs_d2c));

  a_r4_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_c2d) |-> $past(!dut_busy));

  a_r5_release_before_turn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_ctl) |-> $past(!hd_doe));

  a_r5_drive_after_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hd_doe) && $stable(mode_full)) |-> $past(dir_ctl));

  a_r5_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_ctl |-> !hd_doe);

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  a_r9_no_output_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (out_len != '0));

  a_r10_full_no_shared: assert property (@(posedge clk) disable iff (!rst_n)
    mode_full |-> (!hd_doe && dir_ctl));
endmodule

bind nib_target_ctrl nib_target_ctrl_chk #(.NIB_W(NIB_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_full (mode_full),
  .out_len   (out_len),
  .m_tdata   (m_tdata),
  .m_tvalid  (m_tvalid),
  .m_tlast   (m_tlast),
  .m_tready  (m_tready),
  .dir_ctl   (dir_ctl),
  .hd_doe    (hd_doe),
  .hs_c2d    (hs_c2d),
  .hs_d2c    (hs_d2c),
  .dut_busy  (dut_busy)
);

// File: tb/sim_nib_target_ctrl.sv
module sim_nib_target_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_full = 1'b0;
  logic [7:0] out_len = '0;
  logic [7:0] s_tdata = '0;
  logic       s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [7:0] m_tdata;
  logic       m_tvalid, m_tlast;
  logic       m_tready = 1'b1;
  logic       dut_rst, dir_ctl, hd_doe, hs_c2d;
  logic       hs_d2c = 1'b0, dut_busy = 1'b0;
  logic [3:0] hd_dout, fd_dout;
  logic [3:0] hd_din = '0, fd_din = '0;

  always #10 clk = ~clk;

  nib_target_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .out_len(out_len),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .dut_rst(dut_rst), .dir_ctl(dir_ctl), .hd_dout(hd_dout), .hd_doe(hd_doe),
    .hd_din(hd_din), .fd_dout(fd_dout), .fd_din(fd_din), .hs_c2d(hs_c2d),
    .hs_d2c(hs_d2c), .dut_busy(dut_busy)
  );

  int n_tests = 0, n_fail = 0;
  logic [3:0] exp_tx_q[$];
  logic [3:0] sup_q[$];
  logic [8:0] exp_m_q[$];
  int desc_tx_q[$], desc_rx_q[$];
  int tx_left = 0, rx_left = 0, mdl_n = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: answers each request, feeds or records nibbles
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && hs_c2d && !hs_d2c) begin
        logic [3:0] nib;
        if (tx_left == 0 && rx_left == 0 && desc_tx_q.size() > 0) begin
          tx_left = desc_tx_q.pop_front();
          rx_left = desc_rx_q.pop_front();
        end
        for (int k = 0; k < mdl_n % 3; k++) begin
          check(hs_c2d, "R3 request held until answer", hs_c2d, 1);
          @(negedge clk);
        end
        mdl_n++;
        if (tx_left > 0) begin
          nib = mode_full ? fd_dout : hd_dout;
          if (exp_tx_q.size() > 0)
            check(nib == exp_tx_q[0], "R2 sent nibble order", nib, exp_tx_q[0]);
          if (exp_tx_q.size() > 0) void'(exp_tx_q.pop_front());
          if (!mode_full) check(hd_doe && dir_ctl, "R5 controller owns bus when sending", {hd_doe, dir_ctl}, 3);
          tx_left--;
        end else if (rx_left > 0) begin
          nib = (sup_q.size() > 0) ? sup_q.pop_front() : 4'h0;
          if (mode_full) begin
            fd_din = nib;
            hd_din = ~nib;
            check(dir_ctl && !hd_doe, "R10 full-duplex keeps shared bus idle", {hd_doe, dir_ctl}, 1);
          end else begin
            hd_din = nib;
            fd_din = ~nib;
            check(!hd_doe && !dir_ctl, "R5 bus handed to device", {hd_doe, dir_ctl}, 0);
          end
          rx_left--;
        end else begin
          check(1'b0, "R2 unexpected transfer", 1, 0);
        end
        hs_d2c = 1'b1;
        do @(negedge clk); while (hs_c2d);
        hs_d2c = 1'b0;
      end
    end
  end

  // result monitor with back-pressure checks
  initial begin
    bit hold = 1'b0;
    logic [7:0] hd = '0;
    logic hl = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      m_tready = bp_mode ? (cyc % 3 != 0) : 1'b1;
      if (rst_n) begin
        if (hold) begin
          check(m_tvalid && m_tdata == hd && m_tlast == hl, "R7 result held under back-pressure",
                {m_tvalid, m_tlast, m_tdata}, {2'b10 | hl, hd});
          hold = 1'b0;
        end
        if (m_tvalid && m_tready) begin
          if (exp_m_q.size() == 0) check(1'b0, "R9 unexpected result byte", m_tdata, 0);
          else begin
            logic [8:0] e;
            e = exp_m_q.pop_front();
            check(m_tdata == e[7:0], "R6 assembled result byte", m_tdata, e[7:0]);
            check(m_tlast == e[8], "R8 tlast on final byte", m_tlast, e[8]);
          end
        end else if (m_tvalid) begin
          hold = 1'b1;
          hd = m_tdata;
          hl = m_tlast;
        end
      end
    end
  end

  task automatic send_pkt(input logic [7:0] cmd[$], input int len, input logic [7:0] res[$]);
    out_len = len[7:0];
    desc_tx_q.push_back(cmd.size() * 2);
    desc_rx_q.push_back(res.size() * 2);
    foreach (cmd[i]) begin
      exp_tx_q.push_back(cmd[i][7:4]);
      exp_tx_q.push_back(cmd[i][3:0]);
    end
    foreach (res[i]) begin
      sup_q.push_back(res[i][7:4]);
      sup_q.push_back(res[i][3:0]);
      exp_m_q.push_back({(i == res.size() - 1), res[i]});
    end
    foreach (cmd[i]) begin
      s_tdata = cmd[i];
      s_tlast = (i == cmd.size() - 1);
      s_tvalid = 1'b1;
      while (!s_tready) @(negedge clk);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    s_tlast = 1'b0;
    while (exp_m_q.size() > 0 || exp_tx_q.size() > 0 || tx_left > 0 || rx_left > 0 ||
           desc_tx_q.size() > 0 || m_tvalid)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dut_rst == 1'b1, "R1 device reset asserted", dut_rst, 1);
    check(!hs_c2d && dir_ctl && hd_doe, "R1 bus idle and owned", {hs_c2d, dir_ctl, hd_doe}, 3);
    check(!m_tvalid && !s_tready, "R1 streams idle", {m_tvalid, s_tready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dut_rst == 1'b0, "R1 device reset released", dut_rst, 1'b0);

    // half-duplex packet, R2 R6 R8
    send_pkt('{8'h3C, 8'hA1, 8'h7E}, 2, '{8'h5B, 8'hD2});
    // second packet, same length: counter restarted (R11)
    send_pkt('{8'h96}, 2, '{8'h0F, 8'hE4});
    check(exp_m_q.size() == 0, "R11 second packet framed", exp_m_q.size(), 0);

    // back-pressure on results (R7)
    bp_mode = 1'b1;
    send_pkt('{8'h42}, 3, '{8'h19, 8'hC7, 8'h8A});
    bp_mode = 1'b0;

    // zero length: no results, bus kept (R9)
    send_pkt('{8'h11, 8'h22}, 0, '{});
    check(dir_ctl && hd_doe && !m_tvalid, "R9 zero length keeps bus", {dir_ctl, hd_doe, m_tvalid}, 6);

    // busy blocks transfers (R4)
    dut_busy = 1'b1;
    s_tdata = 8'hA5;
    s_tvalid = 1'b1;
    s_tlast = 1'b1;
    out_len = 8'd0;
    repeat (6) begin
      @(negedge clk);
      check(!s_tready && !hs_c2d, "R4 no start while busy", {s_tready, hs_c2d}, 0);
    end
    s_tvalid = 1'b0;
    dut_busy = 1'b0;
    @(negedge clk);
    send_pkt('{8'hA5}, 1, '{8'h6D});

    // full-duplex (R10)
    mode_full = 1'b1;
    @(negedge clk);
    check(!hd_doe && dir_ctl, "R10 shared bus released in full mode", {hd_doe, dir_ctl}, 1);
    send_pkt('{8'hB8, 8'h4F}, 2, '{8'h27, 8'hF1});

    check(exp_m_q.size() == 0 && exp_tx_q.size() == 0, "R8 all results delivered",
          exp_m_q.size() + exp_tx_q.size(), 0);
    summary();
    $finish;
  end
endmodule